// File: doc/BRIEF.md
# Exception Entry State Updater

This block computes every architectural register update a 32-bit RISC core makes on the cycle it enters an exception. Upstream logic picks one cause per cycle and presents it as a 4-bit code with a request strobe. Alongside the strobe it presents the faulting effective address, the current program counter, a flag saying the faulting instruction sits in a branch delay slot, and the present supervision register. One clock later the block drives a redirect PC that points at the handler vector. In the same cycle it drives write strobes and write data for the saved-address register, the saved-status register, the saved-PC register and the live status register. It also strobes a clear of the delay-slot flag.

The saved PC depends on the class of the cause. Faults inside an instruction point back at that instruction. A system call points past it. Asynchronous events point at the instruction that has not yet run. Whenever the instruction is in a delay slot, the saved PC is moved back to the branch. One status bit moves the vector region to the top of the address space. A per-cause ignore mask, used by debug logic, drops a request completely.

Top module: `exc_entry`

## Requirements
- R1: After reset `taken_o` and every write strobe are low. A request code of 0 or of 14..15 is dropped like an ignored one, so nothing is strobed.
- R2: One cycle after an accepted request, `taken_o` pulses for one cycle. `vec_pc_o` equals the cause code shifted left by 8 bits.
- R3: When SR bit 14 (prefix-high) was set at request time, `vec_pc_o` has 0xF0000000 added to it.
- R4: `eear_we_o` pulses with `taken_o`. `eear_o` carries the effective address given with the request.
- R5: `esr_we_o` pulses with `taken_o`. `esr_o` carries the request-time SR without changes.
- R6: `sr_o`, written with `sr_we_o`, is the old SR with the following changes: bit 0 (supervisor) set; bits 1 (tick enable), 2 (interrupt enable), 5 (data MMU enable), 6 (instruction MMU enable) and 12 (overflow-exception enable) cleared; every other bit unchanged.
- R7: For cause 1 (reset), `epcr_we_o` stays low.
- R8: For causes 2,3,4,6,7,9,10,11,13 (instruction faults), `epcr_o` is PC, or PC-4 when the delay flag is set.
- R9: For cause 12 (system call), `epcr_o` is PC+4, or PC when the delay flag is set.
- R10: For causes 5 and 8 (tick, external interrupt), `epcr_o` is PC, or PC-4 when the delay flag is set.
- R11: `dslot_clr_o` pulses with every `taken_o`.
- R12: When bit N of `ignore_mask_i` is set, a request with cause N produces no strobe of any kind in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Exception request strobe |
| cause_i | input | 4 | Cause code 1..13 |
| ea_i | input | 32 | Faulting effective address |
| pc_i | input | 32 | Current PC |
| dslot_i | input | 1 | Instruction is in a delay slot |
| sr_i | input | 32 | Current status register |
| ignore_mask_i | input | 16 | Per-cause drop mask, bit index = cause |
| taken_o | output | 1 | Exception-entry pulse |
| vec_pc_o | output | 32 | Redirect PC |
| eear_we_o | output | 1 | Saved-address write strobe |
| eear_o | output | 32 | Saved-address value |
| esr_we_o | output | 1 | Saved-status write strobe |
| esr_o | output | 32 | Saved-status value |
| epcr_we_o | output | 1 | Saved-PC write strobe |
| epcr_o | output | 32 | Saved-PC value |
| sr_we_o | output | 1 | Status write strobe |
| sr_o | output | 32 | New status value |
| dslot_clr_o | output | 1 | Delay-flag clear strobe |

## Verification
Each result appears exactly one clock after the request is sampled: vector, every strobe and data word, and the delay-flag clear. A dropped request leaves every strobe low in that same cycle. The reference model in the bench turns each request into a predicted output set and delays it by one cycle. The outputs are then compared at the falling edge after every rising edge, so every idle cycle is also checked for silence.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN = 32;
    localparam int CW   = 4;

    typedef enum logic [CW-1:0] {
        C_NONE  = 4'd0,  C_RESET = 4'd1,  C_BUS   = 4'd2,  C_DPF   = 4'd3,
        C_IPF   = 4'd4,  C_TICK  = 4'd5,  C_ALIGN = 4'd6,  C_ILL   = 4'd7,
        C_INT   = 4'd8,  C_DTLB  = 4'd9,  C_ITLB  = 4'd10, C_RANGE = 4'd11,
        C_SYS   = 4'd12, C_TRAP  = 4'd13, C_R14   = 4'd14, C_R15   = 4'd15
    } cause_e;

    typedef enum logic [1:0] {
        K_NOPC  = 2'd0,
        K_FAULT = 2'd1,
        K_NEXT  = 2'd2,
        K_ASYNC = 2'd3
    } epc_kind_e;

    typedef struct packed {
        logic             taken;
        logic [XLEN-1:0]  vec;
        logic [XLEN-1:0]  eear;
        logic [XLEN-1:0]  esr;
        logic             epcr_we;
        logic [XLEN-1:0]  epcr;
        logic [XLEN-1:0]  sr;
    } entry_t;

    function automatic epc_kind_e kind_of(input cause_e c);
        case (c)
            C_RESET:        return K_NOPC;
            C_SYS:          return K_NEXT;
            C_TICK, C_INT:  return K_ASYNC;
            default:        return K_FAULT;
        endcase
    endfunction

    function automatic logic cause_valid(input logic [CW-1:0] c);
        return (c >= 4'd1) && (c <= 4'd13);
    endfunction

endpackage

// File: rtl/exc_vector.sv
module exc_vector #(
    parameter int            W        = 32,
    parameter int            CWID     = 4,
    parameter int            SHIFT    = 8,
    parameter logic [31:0]   HIGH_OFS = 32'hF000_0000
) (
    input  logic [CWID-1:0] cause_i,
    input  logic            high_i,
    output logic [W-1:0]    vec_o
);
    localparam logic [W-1:0] OFS = W'(HIGH_OFS);
    logic [W-1:0] base;

    always_comb begin
        base  = W'(cause_i) << SHIFT;
        vec_o = high_i ? (base + OFS) : base;
    end
endmodule

// File: rtl/exc_sr_update.sv
module exc_sr_update #(
    parameter int W       = 32,
    parameter int SM_BIT  = 0,
    parameter int TEE_BIT = 1,
    parameter int IEE_BIT = 2,
    parameter int DME_BIT = 5,
    parameter int IME_BIT = 6,
    parameter int OVE_BIT = 12
) (
    input  logic [W-1:0] sr_i,
    output logic [W-1:0] sr_o
);
    localparam logic [W-1:0] CLR_MASK = (W'(1) << TEE_BIT) | (W'(1) << IEE_BIT) |
                                        (W'(1) << DME_BIT) | (W'(1) << IME_BIT) |
                                        (W'(1) << OVE_BIT);
    localparam logic [W-1:0] SET_MASK = W'(1) << SM_BIT;

    always_comb sr_o = (sr_i & ~CLR_MASK) | SET_MASK;
endmodule

// File: rtl/exc_epc_sel.sv
module exc_epc_sel
    import exc_entry_pkg::*;
#(
    parameter int W     = 32,
    parameter int ISIZE = 4
) (
    input  cause_e       cause_i,
    input  logic [W-1:0] pc_i,
    input  logic         dslot_i,
    output logic         we_o,
    output logic [W-1:0] epc_o
);
    localparam logic [W-1:0] STEP = W'(ISIZE);
    epc_kind_e kind;

    always_comb begin
        kind  = kind_of(cause_i);
        we_o  = (kind != K_NOPC);
        case (kind)
            K_NEXT:  epc_o = dslot_i ? pc_i : pc_i + STEP;
            K_FAULT,
            K_ASYNC: epc_o = dslot_i ? pc_i - STEP : pc_i;
            default: epc_o = pc_i;
        endcase
    end
endmodule

// File: rtl/exc_entry.sv
module exc_entry
    import exc_entry_pkg::*;
#(
    parameter int SM_BIT  = 0,
    parameter int TEE_BIT = 1,
    parameter int IEE_BIT = 2,
    parameter int DME_BIT = 5,
    parameter int IME_BIT = 6,
    parameter int OVE_BIT = 12,
    parameter int EPH_BIT = 14
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_i,
    input  logic [3:0]  cause_i,
    input  logic [31:0] ea_i,
    input  logic [31:0] pc_i,
    input  logic        dslot_i,
    input  logic [31:0] sr_i,
    input  logic [15:0] ignore_mask_i,
    output logic        taken_o,
    output logic [31:0] vec_pc_o,
    output logic        eear_we_o,
    output logic [31:0] eear_o,
    output logic        esr_we_o,
    output logic [31:0] esr_o,
    output logic        epcr_we_o,
    output logic [31:0] epcr_o,
    output logic        sr_we_o,
    output logic [31:0] sr_o,
    output logic        dslot_clr_o
);
    cause_e       cause;
    logic         accept;
    logic [31:0]  vec_n, sr_n, epc_n;
    logic         epc_we_n;
    entry_t       nxt, cur;

    assign cause  = cause_e'(cause_i);
    assign accept = req_i && cause_valid(cause_i) && !ignore_mask_i[cause_i];

    exc_vector #(.W(XLEN), .CWID(CW)) u_vec (
        .cause_i (cause_i),
        .high_i  (sr_i[EPH_BIT]),
        .vec_o   (vec_n)
    );

    exc_sr_update #(
        .W(XLEN), .SM_BIT(SM_BIT), .TEE_BIT(TEE_BIT), .IEE_BIT(IEE_BIT),
        .DME_BIT(DME_BIT), .IME_BIT(IME_BIT), .OVE_BIT(OVE_BIT)
    ) u_sr (
        .sr_i (sr_i),
        .sr_o (sr_n)
    );

    exc_epc_sel #(.W(XLEN)) u_epc (
        .cause_i (cause),
        .pc_i    (pc_i),
        .dslot_i (dslot_i),
        .we_o    (epc_we_n),
        .epc_o   (epc_n)
    );

    always_comb begin
        nxt.taken   = accept;
        nxt.vec     = vec_n;
        nxt.eear    = ea_i;
        nxt.esr     = sr_i;
        nxt.epcr_we = accept && epc_we_n;
        nxt.epcr    = epc_n;
        nxt.sr      = sr_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur.taken   <= nxt.taken;
            cur.epcr_we <= nxt.epcr_we;
            if (accept) begin
                cur.vec  <= nxt.vec;
                cur.eear <= nxt.eear;
                cur.esr  <= nxt.esr;
                cur.epcr <= nxt.epcr;
                cur.sr   <= nxt.sr;
            end
        end
    end

    assign taken_o     = cur.taken;
    assign vec_pc_o    = cur.vec;
    assign eear_we_o   = cur.taken;
    assign eear_o      = cur.eear;
    assign esr_we_o    = cur.taken;
    assign esr_o       = cur.esr;
    assign epcr_we_o   = cur.epcr_we;
    assign epcr_o      = cur.epcr;
    assign sr_we_o     = cur.taken;
    assign sr_o        = cur.sr;
    assign dslot_clr_o = cur.taken;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_i,
    input logic [3:0]  cause_i,
    input logic [31:0] ea_i,
    input logic [31:0] pc_i,
    input logic        dslot_i,
    input logic [31:0] sr_i,
    input logic [15:0] ignore_mask_i,
    input logic        taken_o,
    input logic        epcr_we_o,
    input logic        dslot_clr_o,
    input logic [31:0] eear_o,
    input logic [31:0] esr_o,
    input logic [31:0] sr_o,
    input logic [31:0] vec_pc_o,
    input logic [31:0] epcr_o
);
    logic ok_q;
    always_ff @(posedge clk) ok_q <= !rst;

    assert_bad_cause_dropped_R1: assert property (@(posedge clk) disable iff (rst)
        (req_i && (cause_i == 4'd0 || cause_i > 4'd13)) |=> !taken_o);

    assert_vector_base_R2: assert property (@(posedge clk) disable iff (rst || !ok_q)
        taken_o |-> (vec_pc_o[7:0] == 8'h00));

    assert_eear_copy_R4: assert property (@(posedge clk) disable iff (rst)
        (req_i && cause_i >= 4'd1 && cause_i <= 4'd13 && !ignore_mask_i[cause_i])
        |=> (taken_o && eear_o == $past(ea_i)));

    assert_esr_copy_R5: assert property (@(posedge clk) disable iff (rst || !ok_q)
        taken_o |-> (esr_o == $past(sr_i)));

    assert_sr_supervisor_R6: assert property (@(posedge clk) disable iff (rst || !ok_q)
        taken_o |-> (sr_o[0] && !sr_o[1] && !sr_o[2] && !sr_o[5] && !sr_o[6] && !sr_o[12]));

    assert_reset_no_epcr_R7: assert property (@(posedge clk) disable iff (rst)
        (req_i && cause_i == 4'd1) |=> !epcr_we_o);

    assert_syscall_epcr_R9: assert property (@(posedge clk) disable iff (rst)
        (req_i && cause_i == 4'd12 && !ignore_mask_i[12])
        |=> (epcr_o == ($past(dslot_i) ? $past(pc_i) : $past(pc_i) + 32'd4)));

    assert_dslot_clear_R11: assert property (@(posedge clk) disable iff (rst)
        taken_o == dslot_clr_o);

    assert_ignored_R12: assert property (@(posedge clk) disable iff (rst)
        (req_i && ignore_mask_i[cause_i]) |=> (!taken_o && !epcr_we_o));
endmodule

bind exc_entry exc_entry_chk u_chk (
    .clk(clk), .rst(rst), .req_i(req_i), .cause_i(cause_i), .ea_i(ea_i),
    .pc_i(pc_i), .dslot_i(dslot_i), .sr_i(sr_i), .ignore_mask_i(ignore_mask_i),
    .taken_o(taken_o), .epcr_we_o(epcr_we_o), .dslot_clr_o(dslot_clr_o),
    .eear_o(eear_o), .esr_o(esr_o), .sr_o(sr_o), .vec_pc_o(vec_pc_o),
    .epcr_o(epcr_o)
);

// File: tb/test_exc_entry.sv
module test_exc_entry;
    logic        clk = 0;
    logic        rst = 1;
    logic        req_i = 0;
    logic [3:0]  cause_i = 0;
    logic [31:0] ea_i = 0, pc_i = 0, sr_i = 0;
    logic        dslot_i = 0;
    logic [15:0] ignore_mask_i = 0;
    logic        taken_o, eear_we_o, esr_we_o, epcr_we_o, sr_we_o, dslot_clr_o;
    logic [31:0] vec_pc_o, eear_o, esr_o, epcr_o, sr_o;

    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    exc_entry i_exc_entry (.*);

    typedef struct {
        bit          tk;
        bit          epwe;
        logic [31:0] vec, ea, esr, ep, sr;
        int          cause;
    } exp_t;
    exp_t q[$];
    exp_t cur_e;
    bit   have = 0;

    function automatic exp_t model(bit r, int c, logic [31:0] ea, logic [31:0] pc,
                                   bit ds, logic [31:0] sr, logic [15:0] ign);
        exp_t e;
        e.cause = c;
        e.tk = r && c >= 1 && c <= 13 && !ign[c];
        e.vec = (c * 256) + (sr[14] ? 32'hF000_0000 : 0);
        e.ea = ea; e.esr = sr;
        e.sr = sr;
        e.sr[0] = 1; e.sr[1] = 0; e.sr[2] = 0; e.sr[5] = 0; e.sr[6] = 0; e.sr[12] = 0;
        e.epwe = e.tk && c != 1;
        if (c == 12) e.ep = ds ? pc : pc + 4;
        else         e.ep = ds ? pc - 4 : pc;
        return e;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(int c);
        if (c == 1) return "R7";
        if (c == 12) return "R9";
        if (c == 5 || c == 8) return "R10";
        return "R8";
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            have = 0;
        end else begin
            q.push_back(model(req_i, int'(cause_i), ea_i, pc_i, dslot_i, sr_i, ignore_mask_i));
            cur_e = q.pop_front();
            have = q.size() == 0;
        end
    end

    always @(negedge clk) begin
        if (!rst && have) begin
            if (!cur_e.tk && cur_e.cause != 0 && ignore_mask_i == 0)
                chk("R1 no strobe", {taken_o, epcr_we_o}, 2'b00);
            else if (!cur_e.tk)
                chk("R12 no strobe", {taken_o, epcr_we_o, sr_we_o, esr_we_o, eear_we_o, dslot_clr_o}, 6'd0);
            else begin
                chk("R2 taken", {31'd0, taken_o}, 32'd1);
                chk(cur_e.vec[31] ? "R3 vector high" : "R2 vector", vec_pc_o, cur_e.vec);
                chk("R4 eear", {eear_we_o, eear_o}, {1'b1, cur_e.ea});
                chk("R5 esr", {esr_we_o, esr_o}, {1'b1, cur_e.esr});
                chk("R6 sr", {sr_we_o, sr_o}, {1'b1, cur_e.sr});
                chk("R11 dslot clear", {31'd0, dslot_clr_o}, 32'd1);
                chk(tag_of(cur_e.cause), {31'd0, epcr_we_o}, {31'd0, cur_e.epwe});
                if (cur_e.epwe) chk(tag_of(cur_e.cause), epcr_o, cur_e.ep);
            end
        end
    end

    task automatic req(int c, logic [31:0] pc, bit ds, logic [31:0] sr);
        @(negedge clk);
        req_i = 1; cause_i = 4'(c); pc_i = pc; dslot_i = ds; sr_i = sr;
        ea_i = pc ^ 32'h1234_5670 ^ (c << 20);
        @(negedge clk);
        req_i = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset taken", {31'd0, taken_o}, 32'd0);
        chk("R1 reset strobes", {27'd0, eear_we_o, esr_we_o, epcr_we_o, sr_we_o, dslot_clr_o}, 32'd0);
        rst = 0;
        @(negedge clk);
        for (int c = 1; c <= 13; c++) begin
            req(c, 32'h0000_2000 + c * 8, 0, 32'hFFFF_BFFF);
            req(c, 32'h0000_4000 + c * 8, 1, 32'h0000_4066);
        end
        req(0, 32'h100, 0, 32'h0);
        req(14, 32'h100, 0, 32'h0);
        req(15, 32'h100, 1, 32'h0);
        ignore_mask_i = 16'h1120;
        req(5, 32'h300, 0, 32'h0);
        req(8, 32'h300, 0, 32'h0);
        req(12, 32'h300, 1, 32'h0);
        req(2, 32'h304, 1, 32'h4000);
        ignore_mask_i = 0;
        for (int c = 1; c <= 13; c++) begin
            @(negedge clk);
            req_i = 1; cause_i = 4'(c); pc_i = 32'h8000_0000 + c * 4;
            dslot_i = c[0]; sr_i = {c[3:0], 28'h00_5A5A} ^ (c[1] ? 32'h4000 : 0);
            ea_i = 32'hDEAD_0000 + c;
        end
        @(negedge clk);
        req_i = 0;
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule